// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer

This block connects a simple word-request port to a single DRAM device whose row and column addresses share one narrow bus. Each accepted request address is split in two. The upper half is driven first with the row strobe, which opens that row. The lower half follows later with the column strobe. Both strobes are active low. The block then returns read data a programmable number of cycles after the column command, as a burst of consecutive words of programmable length.

An opened row stays open. Later requests that hit the same row need only a new column command, so no new row activation is spent on them. A request for a different row first closes the open row. The close waits until the minimum active time is met and all read data has arrived. The new row can open only after the precharge time has elapsed.

An internal interval counter raises a refresh request. When it is raised, the block stops accepting work, closes the row at the next burst boundary, and runs a refresh by taking the column strobe low before the row strobe. Every timing value and the command spacing is sampled while reset is held.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rd_valid` is low, and `req_ready` is high.
- R2: A row opens as a falling `dram_ras_n` with bits [2*MA-1:MA] of the request address on `dram_addr`. A column command is `dram_cas_n` low while `dram_ras_n` is low, with bits [MA-1:0] on `dram_addr`.
- R3: The first column command after a row opens appears no fewer than `cfg_trcd` cycles after the row strobe fell.
- R4: The first read word is on `rd_valid`/`rd_data` exactly `cfg_tcl`+1 cycles after the read column command. A burst has exactly `cfg_burst` words on consecutive cycles, at column addresses that rise by one and wrap inside the row.
- R5: Requests that hit the open row are served with column commands only, with no new row activation.
- R6: A request for another row closes the open row, and `dram_ras_n` then stays high for at least `cfg_trp` cycles before it falls again.
- R7: `dram_ras_n` stays low for at least `cfg_tras` cycles before it rises. This applies to normal rows and to refresh.
- R8: A row is not closed while read data of a burst is still due. `rd_valid` is only high while `dram_ras_n` is low.
- R9: A refresh is issued on its own at least once per `REF_CYC` cycles. It is a cycle with `dram_cas_n` low and `dram_ras_n` high, followed by a low period of `dram_ras_n`. `req_ready` is low from the time a refresh is due until it has finished.
- R10: With `cfg_cmd2` high, no two commands occur on adjacent cycles. A command is an edge of `dram_ras_n` or a cycle with `dram_cas_n` low. With `cfg_cmd2` low, hits to an open row may issue column commands on consecutive cycles.
- R11: A write column command has `dram_we_n` low and the write data on `dram_dq_o`. Later reads of that address return the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration is sampled while it is low |
| cfg_tcl | input | TW | Read latency from column command, in cycles |
| cfg_trcd | input | TW | Minimum cycles from row strobe fall to column command |
| cfg_trp | input | TW | Minimum cycles the row strobe stays high after closing |
| cfg_tras | input | TW | Minimum cycles the row strobe stays low |
| cfg_burst | input | TW | Words returned per read |
| cfg_cmd2 | input | 1 | High: commands at least two cycles apart |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | High for write, low for read |
| req_addr | input | 2*MA | Word address, row in upper half |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read word present |
| rd_data | output | DW | Read word |
| dram_addr | output | MA | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | DW | Write data to device |
| dram_dq_i | input | DW | Read data from device |

## Verification
The assertions watch the strobe pins on every cycle. They cover the row-to-column spacing, the minimum low and high times of the row strobe, the command spacing under the two-cycle rate, read data arriving only with a row open, and the request port being closed while a refresh command is on the pins. Other behaviour can only be shown by the bench's scenarios against a behavioural device. This includes the exact read latency, the burst length and column wrap, the data returned after writes, hits to the open row costing no activation, and refresh happening at all.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int TW = 4;

    typedef struct packed {
        logic [TW-1:0] tcl;
        logic [TW-1:0] trcd;
        logic [TW-1:0] trp;
        logic [TW-1:0] tras;
        logic [TW-1:0] burst;
        logic          cr2;
    } dram_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_RDW,
        ST_REFC,
        ST_REFR
    } dram_st_e;

    function automatic logic [TW-1:0] at_least1(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

endpackage

// File: rtl/dram_sat_cnt.sv
module dram_sat_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = W'(1);
        else if (cnt_q != '1)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int REF_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(REF_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        logic tick;
        tick   = (q.cnt == CW'(REF_CYC - 1));
        d.cnt  = tick ? '0 : q.cnt + CW'(1);
        d.pend = (q.pend && !ack) || tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
    parameter int DW = 16,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [TW-1:0] tcl,
    input  logic [TW-1:0] burst,
    input  logic [DW-1:0] dq_i,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    typedef struct packed {
        logic [TW-1:0] wcnt;
        logic [TW-1:0] beats;
        logic          valid;
        logic [DW-1:0] data;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (launch) begin
            d.wcnt = tcl;
        end else if (q.wcnt != '0) begin
            d.wcnt = q.wcnt - TW'(1);
            if (q.wcnt == TW'(1)) begin
                d.valid = 1'b1;
                d.data  = dq_i;
                d.beats = burst - TW'(1);
            end
        end else if (q.beats != '0) begin
            d.valid = 1'b1;
            d.data  = dq_i;
            d.beats = q.beats - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = q.valid;
    assign rd_data  = q.data;
    assign busy     = (q.wcnt != '0) || (q.beats != '0);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int MA      = 4,
    parameter int DW      = 16,
    parameter int REF_CYC = 1560
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   cfg_tcl,
    input  logic [TW-1:0]   cfg_trcd,
    input  logic [TW-1:0]   cfg_trp,
    input  logic [TW-1:0]   cfg_tras,
    input  logic [TW-1:0]   cfg_burst,
    input  logic            cfg_cmd2,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [2*MA-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic [MA-1:0]   dram_addr,
    output logic            dram_ras_n,
    output logic            dram_cas_n,
    output logic            dram_we_n,
    output logic [DW-1:0]   dram_dq_o,
    input  logic [DW-1:0]   dram_dq_i
);
    localparam int AW = 2 * MA;
    localparam int GW = TW + 1;

    typedef struct packed {
        dram_st_e      st;
        logic [MA-1:0] row;
        logic          pend_v;
        logic          pend_wr;
        logic [AW-1:0] pend_addr;
        logic [DW-1:0] pend_wd;
        logic          ras_n;
        logic          cas_n;
        logic          we_n;
        logic [MA-1:0] addr;
        logic [DW-1:0] dq;
    } ctl_t;

    ctl_t      d, q;
    dram_cfg_t cfg_q;

    logic [GW-1:0] age;
    logic [1:0]    cmd_age;
    logic          ref_pend, ref_ack;
    logic          rd_launch, rd_busy;
    logic          cmd_issue;
    logic          ras_edge;

    dram_sat_cnt #(.W(GW)) u_ras_age (
        .clk(clk), .rst_n(rst_n), .clr(ras_edge), .cnt(age)
    );

    dram_sat_cnt #(.W(2)) u_cmd_age (
        .clk(clk), .rst_n(rst_n), .clr(cmd_issue), .cnt(cmd_age)
    );

    dram_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
    );

    assign rd_launch = !q.cas_n && q.we_n && !q.ras_n;

    dram_rd_capture #(.DW(DW), .TW(TW)) u_cap (
        .clk(clk), .rst_n(rst_n), .launch(rd_launch),
        .tcl(cfg_q.tcl), .burst(cfg_q.burst), .dq_i(dram_dq_i),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(rd_busy)
    );

    always_comb begin
        logic          take, eff_v, eff_wr, consume, gap_ok;
        logic [AW-1:0] eff_addr;
        logic [DW-1:0] eff_wd;
        logic [MA-1:0] eff_row, eff_col;

        d       = q;
        d.cas_n = 1'b1;
        d.we_n  = 1'b1;
        ref_ack   = 1'b0;
        cmd_issue = 1'b0;
        consume   = 1'b0;

        req_ready = !q.pend_v && !ref_pend &&
                    (q.st == ST_IDLE || q.st == ST_OPEN);
        take      = req_valid && req_ready;
        eff_v     = q.pend_v || take;
        eff_wr    = q.pend_v ? q.pend_wr   : req_write;
        eff_addr  = q.pend_v ? q.pend_addr : req_addr;
        eff_wd    = q.pend_v ? q.pend_wd   : req_wdata;
        eff_row   = eff_addr[AW-1:MA];
        eff_col   = eff_addr[MA-1:0];
        gap_ok    = cmd_age >= (cfg_q.cr2 ? 2'd2 : 2'd1);

        case (q.st)
            ST_IDLE: begin
                if (age >= {1'b0, cfg_q.trp} && gap_ok) begin
                    if (ref_pend) begin
                        d.cas_n   = 1'b0;
                        d.st      = ST_REFC;
                        ref_ack   = 1'b1;
                        cmd_issue = 1'b1;
                    end else if (eff_v) begin
                        d.ras_n   = 1'b0;
                        d.addr    = eff_row;
                        d.row     = eff_row;
                        d.st      = ST_OPEN;
                        cmd_issue = 1'b1;
                    end
                end
            end
            ST_OPEN: begin
                if (eff_v && eff_row == q.row) begin
                    if (age >= {1'b0, cfg_q.trcd} && gap_ok) begin
                        d.cas_n   = 1'b0;
                        d.we_n    = !eff_wr;
                        d.addr    = eff_col;
                        d.dq      = eff_wr ? eff_wd : q.dq;
                        consume   = 1'b1;
                        cmd_issue = 1'b1;
                        if (!eff_wr) d.st = ST_RDW;
                    end
                end else if ((eff_v || ref_pend) &&
                             age >= {1'b0, cfg_q.tras} && gap_ok) begin
                    d.ras_n   = 1'b1;
                    d.st      = ST_IDLE;
                    cmd_issue = 1'b1;
                end
            end
            ST_RDW: begin
                if (!rd_launch && !rd_busy) d.st = ST_OPEN;
            end
            ST_REFC: begin
                if (gap_ok) begin
                    d.ras_n   = 1'b0;
                    d.st      = ST_REFR;
                    cmd_issue = 1'b1;
                end
            end
            ST_REFR: begin
                if (age >= {1'b0, cfg_q.tras} && gap_ok) begin
                    d.ras_n   = 1'b1;
                    d.st      = ST_IDLE;
                    cmd_issue = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (take && !consume) begin
            d.pend_v    = 1'b1;
            d.pend_wr   = req_write;
            d.pend_addr = req_addr;
            d.pend_wd   = req_wdata;
        end else if (consume && q.pend_v) begin
            d.pend_v = 1'b0;
        end

        ras_edge = d.ras_n != q.ras_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.row       <= '0;
            q.pend_v    <= 1'b0;
            q.pend_wr   <= 1'b0;
            q.pend_addr <= '0;
            q.pend_wd   <= '0;
            q.ras_n     <= 1'b1;
            q.cas_n     <= 1'b1;
            q.we_n      <= 1'b1;
            q.addr      <= '0;
            q.dq        <= '0;
            cfg_q.tcl   <= at_least1(cfg_tcl);
            cfg_q.trcd  <= at_least1(cfg_trcd);
            cfg_q.trp   <= at_least1(cfg_trp);
            cfg_q.tras  <= at_least1(cfg_tras);
            cfg_q.burst <= at_least1(cfg_burst);
            cfg_q.cr2   <= cfg_cmd2;
        end else begin
            q <= d;
        end
    end

    assign dram_addr  = q.addr;
    assign dram_ras_n = q.ras_n;
    assign dram_cas_n = q.cas_n;
    assign dram_we_n  = q.we_n;
    assign dram_dq_o  = q.dq;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] t_rcd,
    input logic [TW-1:0] t_rp,
    input logic [TW-1:0] t_ras,
    input logic          cr2,
    input logic          ras_n,
    input logic          cas_n,
    input logic          rd_valid,
    input logic          req_ready
);
    localparam int CW = TW + 1;

    logic [CW-1:0] since_fall, since_rise;
    logic          ras_prev, cmd_prev;
    logic          cmd_now;

    assign cmd_now = (ras_n != ras_prev) || !cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_fall <= '1;
            since_rise <= '1;
            ras_prev   <= 1'b1;
            cmd_prev   <= 1'b0;
        end else begin
            ras_prev <= ras_n;
            cmd_prev <= cmd_now;
            if (ras_prev && !ras_n)      since_fall <= CW'(1);
            else if (since_fall != '1)   since_fall <= since_fall + CW'(1);
            if (!ras_prev && ras_n)      since_rise <= CW'(1);
            else if (since_rise != '1)   since_rise <= since_rise + CW'(1);
        end
    end

    p_trcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> since_fall >= {1'b0, t_rcd});

    p_trp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> since_rise >= {1'b0, t_rp});

    p_tras_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> since_fall >= {1'b0, t_ras});

    p_rd_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !ras_n);

    p_ref_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |-> !req_ready);

    p_cmd_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cr2 && cmd_now) |-> !cmd_prev);
endmodule

bind dram_seq_ctrl dram_seq_chk #(.TW(dram_seq_pkg::TW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .t_rcd(cfg_q.trcd), .t_rp(cfg_q.trp), .t_ras(cfg_q.tras), .cr2(cfg_q.cr2),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/dram_seq_ctrl_test.sv
`timescale 1ns/1ps
module dram_seq_ctrl_test;
    localparam int MA = 4;
    localparam int DW = 16;
    localparam int AW = 2 * MA;
    localparam int NW = 1 << AW;
    localparam int REF = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] c_tcl, c_trcd, c_trp, c_tras, c_bl;
    logic c_cr2;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data, dram_dq_o, dram_dq_i;
    logic [MA-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n;

    always #5 clk = ~clk;

    dram_seq_ctrl #(.MA(MA), .DW(DW), .REF_CYC(REF)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_tcl(c_tcl), .cfg_trcd(c_trcd), .cfg_trp(c_trp), .cfg_tras(c_tras),
        .cfg_burst(c_bl), .cfg_cmd2(c_cr2),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_o(dram_dq_o), .dram_dq_i(dram_dq_i)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // behavioural device
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] shadow [NW];
    logic [DW-1:0] dl [16];
    logic [MA-1:0] m_row, m_bcol;
    int  m_bcnt = 0;
    bit  m_arm = 0, m_inref = 0, m_prev_ras = 1;

    always @(posedge clk) begin
        logic [DW-1:0] w;
        w = '0;
        if (m_bcnt > 0) begin
            w = mem[{m_row, m_bcol}];
            m_bcol = m_bcol + 1'b1;
            m_bcnt--;
        end
        if (dram_ras_n) begin
            m_inref = 0;
            if (!dram_cas_n) m_arm = 1;
        end else if (m_prev_ras) begin
            m_inref = m_arm;
            m_arm   = 0;
            m_row   = dram_addr;
        end else if (!dram_cas_n && !m_inref) begin
            if (!dram_we_n) mem[{m_row, dram_addr}] = dram_dq_o;
            else begin
                w      = mem[{m_row, dram_addr}];
                m_bcol = dram_addr + 1'b1;
                m_bcnt = int'(c_bl) - 1;
            end
        end
        m_prev_ras = dram_ras_n;
        dl[0] <= w;
        for (int i = 15; i > 0; i--) dl[i] <= dl[i-1];
    end
    assign dram_dq_i = dl[int'(c_tcl) - 1];

    // scoreboard and pin monitor
    logic [DW-1:0] exp_q [$];
    int cyc = 0, t_fall, t_rise, t_rd, run_rd, run_cas, max_run;
    int n_falls, n_refs, last_lat;
    logic [MA-1:0] last_row, last_col;
    bit p_ras, p_cas, p_cmd, p_rdv;

    task automatic mon_clear();
        t_fall = -100; t_rise = -100; t_rd = 0; run_rd = 0; run_cas = 0;
        max_run = 0; n_falls = 0; n_refs = 0; last_lat = 0;
        p_ras = 1; p_cas = 1; p_cmd = 0; p_rdv = 0;
    endtask

    always @(negedge clk) if (rst_n) begin
        bit cmd;
        cyc++;
        cmd = (dram_ras_n != p_ras) || !dram_cas_n;
        if (c_cr2 && cmd) chk(!p_cmd, "R10 command spacing", 1, 0);
        if (p_ras && !dram_ras_n) begin
            chk(cyc - t_rise >= int'(c_trp), "R6 precharge time", cyc - t_rise, int'(c_trp));
            t_fall = cyc; n_falls++; last_row = dram_addr;
        end
        if (!p_ras && dram_ras_n) begin
            chk(cyc - t_fall >= int'(c_tras), "R7 active time", cyc - t_fall, int'(c_tras));
            t_rise = cyc;
        end
        if (!dram_cas_n && dram_ras_n) begin
            n_refs++;
            chk(!req_ready, "R9 ready during refresh", int'(req_ready), 0);
        end
        if (!dram_cas_n && !dram_ras_n) begin
            if (p_cas) chk(cyc - t_fall >= int'(c_trcd), "R3 row to column", cyc - t_fall, int'(c_trcd));
            last_col = dram_addr;
            run_cas++;
            if (run_cas > max_run) max_run = run_cas;
            if (dram_we_n) t_rd = cyc;
        end else run_cas = 0;
        if (rd_valid) begin
            chk(!dram_ras_n, "R8 data with row open", int'(dram_ras_n), 0);
            if (!p_rdv) begin
                last_lat = cyc - t_rd;
                chk(last_lat == int'(c_tcl) + 1, "R4 read latency", last_lat, int'(c_tcl) + 1);
                run_rd = 0;
            end
            run_rd++;
            if (exp_q.size() == 0) chk(0, "R4 unexpected word", int'(rd_data), -1);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R11 read data", int'(rd_data), int'(e));
            end
        end else if (p_rdv) begin
            chk(run_rd == int'(c_bl), "R4 burst length", run_rd, int'(c_bl));
        end
        p_ras = dram_ras_n; p_cas = dram_cas_n; p_cmd = cmd; p_rdv = rd_valid;
    end

    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] dt);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = dt;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (wr) shadow[a] = dt;
        else for (int i = 0; i < int'(c_bl); i++)
            exp_q.push_back(shadow[{a[AW-1:MA], a[MA-1:0] + MA'(i)}]);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int k;
        idle(1);
        k = 0;
        while (exp_q.size() != 0 && k < 3000) begin @(negedge clk); k++; end
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all words returned", exp_q.size(), 0);
    endtask

    task automatic do_reset(input int tcl, trcd, trp, tras, bl, bit cr2);
        rst_n = 0;
        c_tcl = 4'(tcl); c_trcd = 4'(trcd); c_trp = 4'(trp);
        c_tras = 4'(tras); c_bl = 4'(bl); c_cr2 = cr2;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && !rd_valid, "R1 strobes in reset",
            int'({dram_ras_n, dram_cas_n, dram_we_n, rd_valid}), 14);
        mon_clear();
        rst_n = 1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && !rd_valid && req_ready,
            "R1 idle after reset", int'({dram_ras_n, dram_cas_n, dram_we_n, rd_valid, req_ready}), 29);
    endtask

    task automatic random_mix(input int n, inout logic [15:0] lf);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send(lf[0], {2'b00, lf[2:1], lf[6:3]}, lf ^ 16'h5A3C);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        int f0, r0;
        lf = 16'hACE1;
        for (int i = 0; i < NW; i++) begin
            mem[i] = 16'(i * 37) ^ 16'hA5A5;
            shadow[i] = mem[i];
        end
        // phase A: command rate 1, burst 4
        do_reset(3, 2, 3, 6, 4, 0);
        send(0, 8'h35, '0);
        drain();
        chk(last_row == 4'h3, "R2 row half", int'(last_row), 3);
        chk(last_col == 4'h5, "R2 column half", int'(last_col), 5);
        chk(last_lat == 4, "R4 isolated read latency", last_lat, 4);
        f0 = n_falls;
        for (int i = 0; i < 4; i++) send(1, {4'h3, 4'(i)}, 16'h1000 + 16'(i));
        send(0, 8'h30, '0);
        send(0, 8'h3E, '0);
        drain();
        chk(n_falls == f0, "R5 hits need no activation", n_falls - f0, 0);
        chk(max_run >= 2, "R10 back-to-back columns at rate 1", max_run, 2);
        f0 = n_falls;
        send(0, 8'h92, '0);
        drain();
        chk(n_falls == f0 + 1 && last_row == 4'h9, "R6 miss reopens row", n_falls - f0, 1);
        r0 = n_refs;
        idle(2 * REF + 50);
        chk(n_refs - r0 >= 2, "R9 periodic refresh", n_refs - r0, 2);
        random_mix(40, lf);
        drain();
        // phase B: command rate 2, burst 1
        do_reset(2, 3, 2, 5, 1, 1);
        for (int i = 0; i < 4; i++) send(1, {4'h6, 4'(i)}, 16'h2200 + 16'(i));
        for (int i = 0; i < 4; i++) send(0, {4'h6, 4'(i)}, '0);
        drain();
        chk(max_run == 1, "R10 no adjacent columns at rate 2", max_run, 1);
        chk(last_lat == 3, "R4 latency at tcl 2", last_lat, 3);
        random_mix(30, lf);
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule